// File: doc/BRIEF.md
# Pulse-Density to PCM Decimating Lowpass

This block recovers audio samples from a one-bit pulse-density stream, such as the bitstream of a sigma-delta modulator. Each accepted input bit is widened to either zero or full scale (all ones across the 16-bit sample width). It is then folded into a first-order leaky integrator. The integrator's coefficient is a power of two, so the update needs only a subtraction, an arithmetic shift and an addition, with no multiplier.

A counter tallies the accepted bits. Each time it completes a block of the programmed oversampling length, the filter's current level is captured as one signed 16-bit PCM sample. The level is converted from offset binary to two's complement. The sample appears on a parallel port with a one-cycle strobe.

The same sample is also offered as a byte stream, low byte first, on a valid/ready handshake. The byte stream holds its data for as long as the consumer withholds ready. It never stalls the bit input. If a new sample is captured while bytes of the previous one are still pending, the pending sample is replaced and a sticky overrun flag is raised.

Top module: `pdm_pcm_decimator`

## Requirements
- R1: While reset is held and directly after it, pcm_sample is 0, pcm_valid is 0, byte_valid is 0 and overrun is 0.
- R2: Each accepted bit updates a signed accumulator as acc <= acc + (((x << SHIFT) - acc) >>> SHIFT). Here x is 0xFFFF for bit_in = 1 and 0 for bit_in = 0, and SHIFT defaults to 12. After reset the accumulator holds 0x8000 << SHIFT.
- R3: pcm_valid is high for exactly one cycle, namely the cycle after the edge that accepts the OSR-th bit of a block (OSR defaults to 2048). pcm_sample changes only on that edge and holds its value otherwise.
- R4: The captured sample equals (acc >> SHIFT) - 32768 as a 16-bit two's complement value, where acc includes the block's final bit.
- R5: A cycle with bit_valid low changes neither the accumulator nor the block count, whatever bit_in carries.
- R6: Each captured sample is offered as two bytes on byte_data, bits 7:0 first and bits 15:8 second. A byte is accepted on an edge where byte_valid and byte_ready are both high. While byte_ready is low and no new sample arrives, byte_valid stays high and byte_data stays stable.
- R7: A sample captured while bytes of the previous sample are still unaccepted replaces them: the low byte of the new sample is offered next. In that case overrun goes high and stays high until reset.
- R8: If the final byte of a sample is accepted on the same edge that captures the next sample, overrun is not raised and the new sample's low byte is offered next.
- R9: Asserting rst_n low takes effect without a clock edge. It clears the block count and the overrun flag and restores the accumulator to mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Pulse-density input bit |
| bit_valid | input | 1 | bit_in carries a bit this cycle |
| pcm_sample | output | 16 | Last captured sample, two's complement |
| pcm_valid | output | 1 | One-cycle strobe for a new pcm_sample |
| byte_data | output | 8 | Current byte of the pending sample |
| byte_valid | output | 1 | A byte is offered |
| byte_ready | input | 1 | Consumer accepts the offered byte |
| overrun | output | 1 | Sticky: a pending sample was overwritten |

## Verification
The completion of a filter block and the acceptance of the last pending byte can land on the same clock edge. There the serializer must decide between a clean hand-over and an overrun. The bench provokes this by withholding ready after the low byte is taken. It then counts accepted bits and raises ready exactly on the edge that carries the block's final bit. Correct behaviour shows as a low overrun flag together with the new sample's low byte on the byte port. The contrasting case, with ready withheld across a whole block, must raise the flag.

// File: rtl/pcm_dec_pkg.sv
package pcm_dec_pkg;

  localparam int PCM_W  = 16;
  localparam int BYTE_W = 8;

  // offset binary -> two's complement: invert the most significant bit
  function automatic logic [PCM_W-1:0] offset_to_signed(input logic [PCM_W-1:0] lvl);
    return {~lvl[PCM_W-1], lvl[PCM_W-2:0]};
  endfunction

endpackage

// File: rtl/pcm_leaky_integ.sv
module pcm_leaky_integ #(
  parameter int PCM_W = 16,
  parameter int SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_in,
  output logic [PCM_W-1:0] lvl_nxt
);
  // one guard bit keeps (target - acc) and the shifted step signed-safe
  localparam int ACC_W = PCM_W + SHIFT + 1;
  localparam logic signed [ACC_W-1:0] MID = ACC_W'(1) <<< (PCM_W - 1 + SHIFT);
  localparam logic signed [ACC_W-1:0] TOP = {1'b0, {PCM_W{1'b1}}, {SHIFT{1'b0}}};

  logic signed [ACC_W-1:0] acc_q, target, diff, acc_d;
  logic unused_guard;

  always_comb begin
    target = bit_in ? TOP : '0;
    diff   = target - acc_q;
    acc_d  = en ? acc_q + (diff >>> SHIFT) : acc_q;
  end

  assign lvl_nxt      = acc_d[SHIFT +: PCM_W];
  assign unused_guard = acc_d[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= MID;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/pcm_block_ctr.sv
module pcm_block_ctr #(
  parameter int OSR = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  assign last = en && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcm_byte_ser.sv
module pcm_byte_ser #(
  parameter int PCM_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PCM_W-1:0]  sample,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              overrun
);
  localparam int NB = PCM_W / BYTE_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST_B = IW'(NB - 1);

  logic [PCM_W-1:0] data_q;
  logic [IW-1:0]    idx_q;
  logic             busy_q, ovr_q, take, last_take;

  assign take       = busy_q && byte_ready;
  assign last_take  = take && (idx_q == LAST_B);
  assign byte_valid = busy_q;
  assign byte_data  = data_q[idx_q*BYTE_W +: BYTE_W];
  assign overrun    = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (load) begin
      data_q <= sample;
      idx_q  <= '0;
      busy_q <= 1'b1;
      if (busy_q && !last_take) ovr_q <= 1'b1;
    end else if (take) begin
      if (idx_q == LAST_B) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/pdm_pcm_decimator.sv
module pdm_pcm_decimator
  import pcm_dec_pkg::*;
#(
  parameter int SHIFT = 12,
  parameter int OSR   = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic [PCM_W-1:0]  pcm_sample,
  output logic              pcm_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              overrun
);
  logic [PCM_W-1:0] lvl_nxt;
  logic             blk_last;

  pcm_leaky_integ #(.PCM_W(PCM_W), .SHIFT(SHIFT)) integ_i (
    .clk(clk), .rst_n(rst_n), .en(bit_valid), .bit_in(bit_in), .lvl_nxt(lvl_nxt)
  );

  pcm_block_ctr #(.OSR(OSR)) ctr_i (
    .clk(clk), .rst_n(rst_n), .en(bit_valid), .last(blk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_sample <= '0;
      pcm_valid  <= 1'b0;
    end else begin
      pcm_valid <= blk_last;
      if (blk_last) pcm_sample <= offset_to_signed(lvl_nxt);
    end
  end

  pcm_byte_ser #(.PCM_W(PCM_W), .BYTE_W(BYTE_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .load(blk_last), .sample(offset_to_signed(lvl_nxt)),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .overrun(overrun)
  );
endmodule

// File: rtl/pcm_dec_chk.sv
module pcm_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_valid,
  input logic [15:0] pcm_sample,
  input logic        pcm_valid,
  input logic [7:0]  byte_data,
  input logic        byte_valid,
  input logic        byte_ready,
  input logic        overrun
);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  p_sample_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> $stable(pcm_sample));

  p_idle_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !pcm_valid);

  p_byte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && ($stable(byte_data) || pcm_valid)));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> pcm_valid);
endmodule

bind pdm_pcm_decimator pcm_dec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .pcm_sample(pcm_sample),
  .pcm_valid(pcm_valid), .byte_data(byte_data), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .overrun(overrun)
);

// File: tb/pdm_pcm_decimator_tb_top.sv
`timescale 1ns/1ps
module pdm_pcm_decimator_tb_top;
  localparam int SHIFT = 12;
  localparam int OSR   = 2048;

  logic clk = 1'b0, rst_n = 1'b0, bit_in = 1'b0, bit_valid = 1'b0, byte_ready = 1'b1;
  logic [15:0] pcm_sample;
  logic [7:0]  byte_data;
  logic pcm_valid, byte_valid, overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  longint   m_acc;
  int       m_cnt;
  bit       m_fire;
  logic [15:0] m_last;
  string    cur_req = "R2";

  always #5 clk = ~clk;

  pdm_pcm_decimator #(.SHIFT(SHIFT), .OSR(OSR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .pcm_sample(pcm_sample), .pcm_valid(pcm_valid), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc  = longint'(32768) <<< SHIFT;
    m_cnt  = 0;
    m_fire = 0;
    m_last = 16'h0000;
  endtask

  // Called at a negedge: drive, take one edge, update model, check at next negedge.
  task automatic step(input bit b, input bit v, input bit r);
    longint x;
    bit_in = b; bit_valid = v; byte_ready = r;
    @(posedge clk);
    m_fire = 0;
    if (v) begin
      x = b ? 64'hFFFF : 64'h0;
      m_acc = m_acc + (((x <<< SHIFT) - m_acc) >>> SHIFT);
      m_cnt++;
      if (m_cnt == OSR) begin
        m_cnt  = 0;
        m_fire = 1;
        m_last = 16'((m_acc >>> SHIFT) - 32768);
      end
    end
    @(negedge clk);
    chk(pcm_valid === m_fire, "R3", "pcm_valid strobe", pcm_valid, m_fire);
    if (m_fire) chk(pcm_sample === m_last, cur_req, "captured sample", pcm_sample, m_last);
    else        chk(pcm_sample === m_last, "R3", "sample hold", pcm_sample, m_last);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(pcm_valid === 1'b0 && byte_valid === 1'b0, "R1", "strobes in reset",
        {pcm_valid, byte_valid}, 0);
    chk(overrun === 1'b0, "R9", "overrun cleared by reset", overrun, 0);
    chk(pcm_sample === 16'h0, "R1", "sample in reset", pcm_sample, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic run_until_fire(input int pat, input bit r);
    int i = 0;
    do begin
      case (pat)
        0: step(1'b1, 1'b1, r);
        1: step(1'b0, 1'b1, r);
        2: step((i % 4) != 0, 1'b1, r);
        default: begin
          step(1'b1, 1'b0, r);        // ignored bit
          step(1'b0, 1'b1, r);
        end
      endcase
      i++;
    end while (!m_fire);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(pcm_valid === 0 && byte_valid === 0 && overrun === 0 && pcm_sample === 0,
        "R1", "state after reset", {pcm_sample, pcm_valid, byte_valid, overrun}, 0);
  endtask

  task automatic t_ones_zeros();
    cur_req = "R2";  run_until_fire(0, 1'b1);
    chk($signed(pcm_sample) > 0, "R4", "ones block positive", pcm_sample, m_last);
    cur_req = "R4";  run_until_fire(1, 1'b1);
    cur_req = "R2";  run_until_fire(1, 1'b1);
    chk($signed(pcm_sample) < 0, "R4", "zeros block negative", pcm_sample, m_last);
    run_until_fire(2, 1'b1);
    run_until_fire(2, 1'b1);
  endtask

  task automatic t_gaps();
    cur_req = "R5";
    run_until_fire(3, 1'b1);
  endtask

  task automatic t_bytes();
    repeat (3) step(1'b0, 1'b0, 1'b1);
    cur_req = "R2";
    run_until_fire(0, 1'b0);
    chk(byte_valid === 1'b1, "R6", "byte offered", byte_valid, 1);
    chk(byte_data === m_last[7:0], "R6", "low byte first", byte_data, m_last[7:0]);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk(byte_valid === 1'b1 && byte_data === m_last[7:0], "R6", "low byte held",
        byte_data, m_last[7:0]);
    step(1'b0, 1'b0, 1'b1);
    chk(byte_data === m_last[15:8], "R6", "high byte second", byte_data, m_last[15:8]);
    step(1'b0, 1'b0, 1'b1);
    chk(byte_valid === 1'b0, "R6", "drained", byte_valid, 0);
    chk(overrun === 1'b0, "R7", "no overrun when drained", overrun, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cur_req = "R8";
    run_until_fire(2, 1'b0);
    step(1'b1, 1'b1, 1'b1);                  // low byte taken
    while (m_cnt != OSR - 1) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);                  // high byte taken on capture edge
    chk(m_fire == 1, "R8", "capture lands on final byte", m_fire, 1);
    chk(overrun === 1'b0, "R8", "no overrun on same-edge hand-over", overrun, 0);
    chk(byte_valid === 1'b1 && byte_data === m_last[7:0], "R8", "new low byte offered",
        byte_data, m_last[7:0]);
  endtask

  task automatic t_overrun();
    cur_req = "R7";
    run_until_fire(1, 1'b0);
    chk(overrun === 1'b1, "R7", "overrun raised", overrun, 1);
    chk(byte_data === m_last[7:0], "R7", "pending replaced by new sample", byte_data, m_last[7:0]);
    repeat (4) step(1'b0, 1'b0, 1'b1);
    chk(overrun === 1'b1, "R7", "overrun sticky", overrun, 1);
  endtask

  task automatic t_async_reset();
    repeat (700) step(1'b1, 1'b1, 1'b1);   // part of a block
    do_reset();
    cur_req = "R9";
    run_until_fire(2, 1'b1);
    chk(overrun === 1'b0, "R9", "overrun stays clear", overrun, 0);
  endtask

  initial begin
    model_reset();
    t_reset_state();
    t_ones_zeros();
    t_gaps();
    t_bytes();
    t_same_cycle();
    t_overrun();
    t_async_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule